// File: doc/BRIEF.md
# Row-Hit-First DRAM Bank Request Scheduler

This block sits in a memory controller in front of a single DRAM bank. It holds a small pool of pending read/write requests. Each request carries a row address, a column address and the ID of the thread that issued it. When a request is accepted, the block gives it an arrival stamp. The block also tracks the bank's row buffer, which is either empty or holds one open row. Whenever the bank is free, the block chooses one pending request, issues it, and reports how the access meets the row buffer: a hit on the open row, an access to an empty bank, or a conflict that replaces the open row.

Requests are not served in arrival order. Any request that targets the currently open row wins over every request that targets another row, however old. Age decides only between requests of the same class. This keeps row-buffer locality high, but a thread that streams through one row can hold back an older request from another thread for as long as it keeps feeding that row. After each issue the block holds `busy` for a number of cycles set by the access kind. This models the longer service time of empty and conflict accesses.

Top module: `dram_rowhit_sched`

## Requirements
- R1: After reset, `iss_valid` and `busy` are 0, `req_ready` is 1, and the bank has no open row.
- R2: `iss_kind` uses the encoding 0 = hit, 1 = empty, 2 = conflict. An access is empty when no row is open, a hit when its row equals the open row, and a conflict otherwise.
- R3: When at least one pending request targets the open row, the issued request is one of those, even if requests to other rows are older.
- R4: Among pending requests of the same hit status, the one accepted earliest is issued first.
- R5: The row of each issued request becomes the open row, so later requests to that row are hits. A row stays open until a conflict replaces it.
- R6: After an issue, `busy` is high for exactly LAT_HIT (1), LAT_EMPTY (2) or LAT_CONF (3) cycles, starting in the cycle `iss_valid` is high. No request is issued while `busy` is high.
- R7: When `busy` is low and at least one request is pending, a request is issued at the next clock edge. `iss_valid` is high for exactly one cycle per accepted request. `iss_row`, `iss_col` and `iss_tid` carry that request's fields.
- R8: `req_ready` is low exactly when DEPTH (8) requests are pending. A request offered while `req_ready` is low is dropped and never issued.
- R9: If a stream of 128 requests to the open row arrives after an older request to another row, all 128 are issued as hits before the older request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_row | input | ROW_W | Row address of the offered request |
| req_col | input | COL_W | Column address of the offered request |
| req_tid | input | TID_W | Thread ID of the offered request |
| req_ready | output | 1 | A buffer slot is free; request accepted when valid and ready |
| iss_valid | output | 1 | One-cycle pulse: a request is issued to the bank |
| iss_row | output | ROW_W | Row of the issued request |
| iss_col | output | COL_W | Column of the issued request |
| iss_tid | output | TID_W | Thread ID of the issued request |
| iss_kind | output | 2 | Access kind: 0 hit, 1 empty, 2 conflict |
| busy | output | 1 | Bank is serving the last issued access |

## Verification
The hardest case to reach from the ports is a long starvation episode. The buffer must stay full of hits to the open row while an older request to another row keeps losing arbitration, and that has to last for 128 consecutive issues. The bench reaches it by opening a row, inserting one conflicting request, and then offering a new same-row request in every cycle that `req_ready` allows, which keeps the buffer saturated. A second hard case is an offer made exactly while the buffer is full. The bench fills the buffer faster than the bank drains it, offers a request to a marker row in a cycle where `req_ready` is low, and confirms after draining that this row never appears at the issue port.

// File: rtl/sched_pkg.sv
// Shared types for the row-hit-first bank scheduler.
// Assumes a single bank whose row buffer holds at most one open row.
package sched_pkg;

    // Access kind reported with each issue; the encoding is visible at the top ports.
    typedef enum logic [1:0] {
        ACC_HIT      = 2'd0,
        ACC_EMPTY    = 2'd1,
        ACC_CONFLICT = 2'd2
    } acc_kind_e;

    // Classify an access from the row-buffer state and a row comparison.
    function automatic acc_kind_e classify(input logic row_open, input logic same_row);
        if (!row_open)
            return ACC_EMPTY;
        else if (same_row)
            return ACC_HIT;
        else
            return ACC_CONFLICT;
    endfunction

endpackage

// File: rtl/sched_req_buf.sv
// Pending-request pool for the bank scheduler.
// Stores up to DEPTH requests in slots. Each slot holds row, column, thread ID
// and an arrival stamp taken from a free-running counter.
// A new request goes into the lowest free slot. One slot is freed per
// dequeue. Assumes the stamp counter does not wrap during the life of a request.
module sched_req_buf #(
    parameter int DEPTH = 8,
    parameter int ROW_W = 14,
    parameter int COL_W = 7,
    parameter int TID_W = 2,
    parameter int AGE_W = 32,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enq_valid,
    input  logic [ROW_W-1:0]             enq_row,
    input  logic [COL_W-1:0]             enq_col,
    input  logic [TID_W-1:0]             enq_tid,
    output logic                         enq_ready,
    input  logic                         deq_en,
    input  logic [IDX_W-1:0]             deq_idx,
    output logic [DEPTH-1:0]             slot_valid,
    output logic [DEPTH-1:0][ROW_W-1:0]  slot_row,
    output logic [DEPTH-1:0][COL_W-1:0]  slot_col,
    output logic [DEPTH-1:0][TID_W-1:0]  slot_tid,
    output logic [DEPTH-1:0][AGE_W-1:0]  slot_age
);

    logic [DEPTH-1:0]            valid_q;
    logic [DEPTH-1:0][ROW_W-1:0] row_q;
    logic [DEPTH-1:0][COL_W-1:0] col_q;
    logic [DEPTH-1:0][TID_W-1:0] tid_q;
    logic [DEPTH-1:0][AGE_W-1:0] age_q;
    logic [AGE_W-1:0]            stamp_q;
    logic [IDX_W-1:0]            free_idx;
    logic                        have_free;
    logic                        enq_fire;

    // Find the lowest-numbered free slot.
    always_comb begin
        free_idx  = '0;
        have_free = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_idx  = IDX_W'(i);
                have_free = 1'b1;
            end
        end
    end

    assign enq_ready = have_free;
    assign enq_fire  = enq_valid && have_free;

    // Slot occupancy and the arrival-stamp counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            stamp_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (enq_fire && free_idx == IDX_W'(i))
                    valid_q[i] <= 1'b1;
                else if (deq_en && deq_idx == IDX_W'(i))
                    valid_q[i] <= 1'b0;
            end
            if (enq_fire)
                stamp_q <= stamp_q + 1'b1;
        end
    end

    // Capture request fields and stamp into the chosen slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (enq_fire && free_idx == IDX_W'(i)) begin
                row_q[i] <= enq_row;
                col_q[i] <= enq_col;
                tid_q[i] <= enq_tid;
                age_q[i] <= stamp_q;
            end
        end
    end

    assign slot_valid = valid_q;
    assign slot_row   = row_q;
    assign slot_col   = col_q;
    assign slot_tid   = tid_q;
    assign slot_age   = age_q;

    AST_DEQ_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
        deq_en |-> valid_q[deq_idx]);                                   // R7
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_ready && !deq_en) |=> !enq_ready);                        // R8

endmodule

// File: rtl/sched_pick.sv
// Arbitration logic for the bank scheduler (purely combinational).
// First class: slots whose row equals the open row. Among the slots of the
// best class present, the smallest arrival stamp wins. On equal stamps the
// lower slot index wins.
// Assumes stamps of live slots never wrap.
module sched_pick #(
    parameter int DEPTH = 8,
    parameter int ROW_W = 14,
    parameter int AGE_W = 32,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]             slot_valid,
    input  logic [DEPTH-1:0][ROW_W-1:0]  slot_row,
    input  logic [DEPTH-1:0][AGE_W-1:0]  slot_age,
    input  logic                         open_valid,
    input  logic [ROW_W-1:0]             open_row,
    output logic                         pick_any,
    output logic [IDX_W-1:0]             pick_idx,
    output logic                         pick_hit,
    output logic [DEPTH-1:0]             hit_vec
);

    // Per-slot row-hit flags.
    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign hit_vec[g] = slot_valid[g] && open_valid && (slot_row[g] == open_row);
    end

    logic [AGE_W-1:0] best_age;

    // Linear scan keeping the best candidate: hit class first, then oldest stamp.
    always_comb begin
        pick_any = 1'b0;
        pick_idx = '0;
        pick_hit = 1'b0;
        best_age = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_valid[i]) begin
                if (!pick_any
                    || (hit_vec[i] && !pick_hit)
                    || (hit_vec[i] == pick_hit && slot_age[i] < best_age)) begin
                    pick_any = 1'b1;
                    pick_idx = IDX_W'(i);
                    pick_hit = hit_vec[i];
                    best_age = slot_age[i];
                end
            end
        end
    end

endmodule

// File: rtl/sched_bank.sv
// Row-buffer state and service-time model for one bank.
// Records the row opened by each issue. Loads a countdown with the latency of
// the access kind, and reports busy while the countdown is non-zero.
// Assumes every latency parameter is at least 1.
module sched_bank
    import sched_pkg::*;
#(
    parameter int ROW_W     = 14,
    parameter int LAT_HIT   = 1,
    parameter int LAT_EMPTY = 2,
    parameter int LAT_CONF  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_fire,
    input  logic [ROW_W-1:0] issue_row,
    input  acc_kind_e        issue_kind,
    output logic             open_valid,
    output logic [ROW_W-1:0] open_row,
    output logic             busy
);

    localparam int LAT_MAX = (LAT_CONF > LAT_EMPTY)
                           ? ((LAT_CONF > LAT_HIT) ? LAT_CONF : LAT_HIT)
                           : ((LAT_EMPTY > LAT_HIT) ? LAT_EMPTY : LAT_HIT);
    localparam int LAT_W   = $clog2(LAT_MAX + 1);

    logic [LAT_W-1:0] cnt_q;
    logic [LAT_W-1:0] lat_sel;

    // Service latency for the kind being issued.
    always_comb begin
        unique case (issue_kind)
            ACC_HIT:   lat_sel = LAT_W'(LAT_HIT);
            ACC_EMPTY: lat_sel = LAT_W'(LAT_EMPTY);
            default:   lat_sel = LAT_W'(LAT_CONF);
        endcase
    end

    // Open-row register: empty after reset, then the row of the last issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_valid <= 1'b0;
            open_row   <= '0;
        end else if (issue_fire) begin
            open_valid <= 1'b1;
            open_row   <= issue_row;
        end
    end

    // Busy countdown: loaded on issue, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (issue_fire)
            cnt_q <= lat_sel;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    AST_NO_ISSUE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !issue_fire);                                          // R6
    AST_ROW_OPENED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |=> (open_valid && open_row == $past(issue_row)));   // R5
    AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |=> busy);                                           // R6

endmodule

// File: rtl/dram_rowhit_sched.sv
// Row-hit-first request scheduler for one DRAM bank.
// Accepts requests through a ready/valid port into a pool of DEPTH slots.
// When the bank is not busy, picks one pending request: open-row hits first,
// then oldest. It issues that request as a one-cycle pulse tagged hit, empty or
// conflict, and holds busy for the latency of that kind.
// Assumes all latency parameters are at least 1.
module dram_rowhit_sched
    import sched_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 7,
    parameter int TID_W     = 2,
    parameter int AGE_W     = 32,
    parameter int LAT_HIT   = 1,
    parameter int LAT_EMPTY = 2,
    parameter int LAT_CONF  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [TID_W-1:0] req_tid,
    output logic             req_ready,
    output logic             iss_valid,
    output logic [ROW_W-1:0] iss_row,
    output logic [COL_W-1:0] iss_col,
    output logic [TID_W-1:0] iss_tid,
    output logic [1:0]       iss_kind,
    output logic             busy
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]            slot_valid;
    logic [DEPTH-1:0][ROW_W-1:0] slot_row;
    logic [DEPTH-1:0][COL_W-1:0] slot_col;
    logic [DEPTH-1:0][TID_W-1:0] slot_tid;
    logic [DEPTH-1:0][AGE_W-1:0] slot_age;
    logic                        pick_any;
    logic [IDX_W-1:0]            pick_idx;
    logic                        pick_hit;
    logic [DEPTH-1:0]            hit_vec;
    logic                        open_valid;
    logic [ROW_W-1:0]            open_row;
    logic                        issue_fire;
    logic [ROW_W-1:0]            pick_row;
    acc_kind_e                   pick_kind;

    sched_req_buf #(
        .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .TID_W(TID_W),
        .AGE_W(AGE_W), .IDX_W(IDX_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_valid  (req_valid),
        .enq_row    (req_row),
        .enq_col    (req_col),
        .enq_tid    (req_tid),
        .enq_ready  (req_ready),
        .deq_en     (issue_fire),
        .deq_idx    (pick_idx),
        .slot_valid (slot_valid),
        .slot_row   (slot_row),
        .slot_col   (slot_col),
        .slot_tid   (slot_tid),
        .slot_age   (slot_age)
    );

    sched_pick #(
        .DEPTH(DEPTH), .ROW_W(ROW_W), .AGE_W(AGE_W), .IDX_W(IDX_W)
    ) u_pick (
        .slot_valid (slot_valid),
        .slot_row   (slot_row),
        .slot_age   (slot_age),
        .open_valid (open_valid),
        .open_row   (open_row),
        .pick_any   (pick_any),
        .pick_idx   (pick_idx),
        .pick_hit   (pick_hit),
        .hit_vec    (hit_vec)
    );

    sched_bank #(
        .ROW_W(ROW_W), .LAT_HIT(LAT_HIT), .LAT_EMPTY(LAT_EMPTY), .LAT_CONF(LAT_CONF)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_fire (issue_fire),
        .issue_row  (pick_row),
        .issue_kind (pick_kind),
        .open_valid (open_valid),
        .open_row   (open_row),
        .busy       (busy)
    );

    // Issue whenever the bank is free and something is pending; classify the pick.
    always_comb begin
        issue_fire = pick_any && !busy;
        pick_row   = slot_row[pick_idx];
        pick_kind  = classify(open_valid, pick_row == open_row);
    end

    // Register the issue outputs: a one-cycle pulse per issued request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= 1'b0;
            iss_row   <= '0;
            iss_col   <= '0;
            iss_tid   <= '0;
            iss_kind  <= 2'd0;
        end else begin
            iss_valid <= issue_fire;
            if (issue_fire) begin
                iss_row  <= pick_row;
                iss_col  <= slot_col[pick_idx];
                iss_tid  <= slot_tid[pick_idx];
                iss_kind <= pick_kind;
            end
        end
    end

    AST_HIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_fire && !pick_hit) |-> (hit_vec == '0));                 // R3
    AST_HIT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_fire && pick_hit) |-> (pick_kind == ACC_HIT));           // R2
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !iss_valid);                                      // R6
    AST_BUSY_WITH_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> busy);                                            // R6

endmodule

// File: tb/test_dram_rowhit_sched.sv
`timescale 1ns/1ps
// Self-checking bench: a queue model in arrival order predicts every issue.
module test_dram_rowhit_sched;

    localparam int DEPTH = 8;
    localparam int ROW_W = 4;
    localparam int COL_W = 4;
    localparam int TID_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [TID_W-1:0] req_tid = '0;
    logic             req_ready;
    logic             iss_valid;
    logic [ROW_W-1:0] iss_row;
    logic [COL_W-1:0] iss_col;
    logic [TID_W-1:0] iss_tid;
    logic [1:0]       iss_kind;
    logic             busy;

    dram_rowhit_sched #(
        .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .TID_W(TID_W), .AGE_W(16)
    ) i_dram_rowhit_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
        .req_col(req_col), .req_tid(req_tid), .req_ready(req_ready),
        .iss_valid(iss_valid), .iss_row(iss_row), .iss_col(iss_col),
        .iss_tid(iss_tid), .iss_kind(iss_kind), .busy(busy)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int q_row[$];
    int q_col[$];
    int q_tid[$];
    bit m_open = 1'b0;
    int m_open_row = 0;
    int busy_left = 0;
    bit exp_issue = 1'b0;
    bit last_valid = 1'b0;
    int last_row = 0;
    int last_kind = 0;
    int last_tid = 0;
    int marker_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare the issue port and busy against the model, then update the model.
    task automatic observe(output bit idle);
        int idx;
        int ek;
        bit found;
        chk(iss_valid == exp_issue, "R7 issue timing", iss_valid, exp_issue);
        last_valid = iss_valid;
        if (iss_valid && q_row.size() > 0) begin
            idx = 0;
            found = 1'b0;
            if (m_open)
                foreach (q_row[k])
                    if (!found && q_row[k] == m_open_row) begin
                        idx = k;
                        found = 1'b1;
                    end
            ek = !m_open ? 1 : (found ? 0 : 2);
            chk(int'(iss_kind) == ek, "R2 kind", iss_kind, ek);
            if (found) chk(int'(iss_row) == q_row[idx], "R3 hit-first row", iss_row, q_row[idx]);
            else       chk(int'(iss_row) == q_row[idx], "R4 oldest row", iss_row, q_row[idx]);
            chk(int'(iss_col) == q_col[idx], "R7 column", iss_col, q_col[idx]);
            chk(int'(iss_tid) == q_tid[idx], "R7 thread", iss_tid, q_tid[idx]);
            m_open = 1'b1;
            m_open_row = q_row[idx];
            q_row.delete(idx);
            q_col.delete(idx);
            q_tid.delete(idx);
            busy_left = ek + 1;
        end
        if (iss_valid) begin
            last_row = int'(iss_row);
            last_kind = int'(iss_kind);
            last_tid = int'(iss_tid);
            if (iss_row == 4'd15) marker_seen++;
        end
        chk(busy == (busy_left > 0), "R6 busy", busy, busy_left > 0);
        idle = (busy_left == 0);
        if (busy_left > 0) busy_left--;
    endtask

    // One clock: check ready, drive an offer, observe at the next falling edge.
    task automatic cycle(input bit v, input int row, input int col, input int tid, output bit acc);
        bit idle;
        chk(req_ready == (q_row.size() < DEPTH), "R8 ready", req_ready, q_row.size() < DEPTH);
        req_valid = v;
        req_row = ROW_W'(row);
        req_col = COL_W'(col);
        req_tid = TID_W'(tid);
        #1;
        acc = v && req_ready;
        @(negedge clk);
        observe(idle);
        if (acc) begin
            q_row.push_back(row);
            q_col.push_back(col);
            q_tid.push_back(tid);
        end
        exp_issue = idle && (q_row.size() > 0);
    endtask

    task automatic drain();
        bit a;
        for (int i = 0; i < 200 && (q_row.size() > 0 || busy_left > 0); i++)
            cycle(1'b0, 0, 0, 0, a);
        cycle(1'b0, 0, 0, 0, a);
        cycle(1'b0, 0, 0, 0, a);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stimulus
        bit a;
        int hits;
        int sent;
        logic [15:0] lfsr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(iss_valid == 1'b0, "R1 iss_valid", iss_valid, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);

        // R1: first access sees an empty bank
        cycle(1'b1, 5, 1, 0, a);
        cycle(1'b0, 0, 0, 0, a);
        chk(last_valid && last_kind == 1, "R1 first access empty", last_kind, 1);

        // R9: older request to row 9, then a 128-request stream to open row 5
        cycle(1'b1, 9, 2, 1, a);
        sent = 0;
        hits = 0;
        while (sent < 128) begin
            cycle(1'b1, 5, sent % 16, 0, a);
            if (a) sent++;
            if (last_valid && last_tid == 0 && last_kind == 0) hits++;
            chk(!(last_valid && last_tid == 1) || sent == 128, "R9 victim held", last_tid, 0);
        end
        while (!(last_valid && last_tid == 1)) begin
            cycle(1'b0, 0, 0, 0, a);
            if (last_valid && last_tid == 0 && last_kind == 0) hits++;
        end
        chk(hits == 128, "R9 hits ahead", hits, 128);
        chk(last_kind == 2, "R9 victim conflict", last_kind, 2);
        drain();

        // R5: after the conflict opened row 9, a new row-9 access is a hit
        cycle(1'b1, 9, 3, 2, a);
        drain();
        chk(last_row == 9 && last_kind == 0, "R5 new row hit", last_kind, 0);

        // R8: fill the buffer, offer a marker request while full
        for (int i = 0; i < 40 && req_ready; i++) cycle(1'b1, i % 3, i % 16, 3, a);
        chk(req_ready == 1'b0, "R8 full", req_ready, 0);
        cycle(1'b1, 15, 7, 3, a);
        chk(a == 1'b0, "R8 offer refused", a, 0);
        drain();
        chk(marker_seen == 0, "R8 dropped offer never issued", marker_seen, 0);

        // R3 R4 R6 R7: pseudo-random sweep over rows 0..3
        lfsr = 16'hACE1;
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[0] | lfsr[5], int'(lfsr[3:2]), int'(lfsr[11:8]), int'(lfsr[7:6]), a);
        end
        drain();
        chk(q_row.size() == 0, "R7 all issued", q_row.size(), 0);
        chk(busy == 1'b0 && iss_valid == 1'b0, "R6 idle at end", busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule